// File: doc/BRIEF.md
# Successive-Approximation Converter Control Emulator

This block models the digital control side of a 12-bit sampling converter so that a system can talk to it over the converter's usual pins, either in a simulation or on an FPGA board. The analog front end is replaced by a `sample_i` port. The block captures that port when a conversion begins. It holds a busy status for a fixed number of clock cycles and then offers the captured code on a data bus, with a separate output-enable flag standing in for the three-state drivers.

Two ways of use are supported. In full-bus operation, a host drives the enable, the active-low select, the read/convert line and a byte-address bit, and picks 12-bit or 8-bit transfers with a width pin. In stand-alone operation the enable and width pins are held high and the select and address pins are held low, so the read/convert line alone runs the block. A low pulse on that line starts a conversion and floats the outputs at once. The outputs come back on their own once the result is ready.

The bus carries no flow control. A read shows data in the same cycle as the decode, and the sample is taken without a handshake in the cycle a conversion starts.

Top module: `adc_ctrl_emu`

## Requirements
- R1: After reset, `busy_o`, `data_oe_o`, `addr_viol_o` are 0 and `data_o` is all zeros.
- R2: A conversion starts on the first clock edge at which `en_i`=1, `cs_n_i`=0 and `rd_conv_i`=0 all hold, whichever of the three became true last. `busy_o` is 1 from the following cycle.
- R3: `busy_o` stays high for exactly CONV_CYCLES clock cycles (default 25) and then returns low.
- R4: The result is the value of `sample_i` at the starting edge. Later changes of `sample_i` do not alter it.
- R5: A convert command that arrives while `busy_o` is high is ignored: neither the busy length nor the result changes.
- R6: Starts are edge-triggered. A convert condition held unbroken through a whole conversion does not start another one.
- R7: `data_oe_o` = `en_i` & !`cs_n_i` & `rd_conv_i` & !`busy_o`, with no clock delay. `data_o` is all zeros whenever `data_oe_o` is 0.
- R8: With `wide_i`=1, a read puts the full 12-bit result on `data_o`, and `addr_i` has no effect.
- R9: With `wide_i`=0, the byte appears on `data_o[11:4]` and `data_o[3:0]` is 0. `addr_i`=0 selects result bits 11..4. `addr_i`=1 selects result bits 3..0 followed by four zeros.
- R10: In stand-alone use, a falling `rd_conv_i` drops `data_oe_o` in the same cycle. After a low pulse, `data_oe_o` returns high with the new result once `busy_o` falls.
- R11: `addr_viol_o` is 1 for the cycle after an edge at which `addr_i` differs from its value at the previous edge. At both of those edges a byte-mode read (`wide_i`=0, `data_oe_o`=1) must be active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Chip enable, active high |
| cs_n_i | input | 1 | Chip select, active low |
| rd_conv_i | input | 1 | 1 = read, 0 = convert |
| addr_i | input | 1 | Byte select in 8-bit mode |
| wide_i | input | 1 | 1 = 12-bit transfers, 0 = byte transfers |
| sample_i | input | 12 | Stand-in for the analog input |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | 12 | Data bus value |
| data_oe_o | output | 1 | Data bus drive enable |
| addr_viol_o | output | 1 | Address changed during a byte read |

## Verification
The hardest case to reach is a second convert edge that arrives inside a running conversion. The select line must rise and fall again while busy is high, with a different sample on the input. The bench toggles the select at fixed counts inside the loop that measures the busy length. It then checks that the length is still CONV_CYCLES and that the read returns the first sample. The address violation likewise needs a byte read held across two edges with the address flipped between them. A directed step makes that flip and then confirms that the flag falls back after one cycle.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  // decoded bus request for one cycle
  typedef struct packed {
    logic conv_lvl;  // convert condition present
    logic rd_lvl;    // read condition present (before busy gating)
  } bus_req_t;
endpackage

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
  import adc_emu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic cs_n_i,
  input  logic rd_conv_i,
  input  logic busy_i,
  output logic conv_start_o,
  output logic rd_active_o
);
  bus_req_t req;
  logic     conv_lvl_q;

  always_comb begin
    req.conv_lvl = en_i & ~cs_n_i & ~rd_conv_i;
    req.rd_lvl   = en_i & ~cs_n_i & rd_conv_i;
  end

  // remember last level so only a new convert condition counts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_lvl_q <= 1'b0;
    else        conv_lvl_q <= req.conv_lvl;
  end

  assign conv_start_o = req.conv_lvl & ~conv_lvl_q & ~busy_i;
  assign rd_active_o  = req.rd_lvl & ~busy_i;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      remain_q <= '0;
      result_o <= '0;
    end else if (start_i) begin
      busy_o   <= 1'b1;
      remain_q <= LAST;
      result_o <= sample_i;
    end else if (busy_o) begin
      if (remain_q == '0) busy_o <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_out_sel.sv
module adc_out_sel #(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_active_i,
  input  logic              wide_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              addr_viol_o
);
  localparam int LO_W  = DATA_W - BYTE_W;
  localparam int PAD_W = DATA_W - BYTE_W;

  logic [BYTE_W-1:0] hi_byte, lo_byte, pick;
  logic              byte_rd_q, addr_q;
  logic              byte_rd;

  assign hi_byte = result_i[DATA_W-1 -: BYTE_W];

  generate
    if (LO_W < BYTE_W) begin : g_pad_lo
      assign lo_byte = {result_i[LO_W-1:0], {(BYTE_W-LO_W){1'b0}}};
    end else begin : g_full_lo
      assign lo_byte = result_i[BYTE_W-1:0];
    end
  endgenerate

  assign pick      = addr_i ? lo_byte : hi_byte;
  assign data_oe_o = rd_active_i;
  assign byte_rd   = rd_active_i & ~wide_i;

  always_comb begin
    if (!rd_active_i) data_o = '0;
    else if (wide_i)  data_o = result_i;
    else              data_o = {pick, {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_rd_q   <= 1'b0;
      addr_q      <= 1'b0;
      addr_viol_o <= 1'b0;
    end else begin
      byte_rd_q   <= byte_rd;
      addr_q      <= addr_i;
      addr_viol_o <= byte_rd & byte_rd_q & (addr_i != addr_q);
    end
  end
endmodule

// File: rtl/adc_ctrl_emu.sv
module adc_ctrl_emu #(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int CONV_CYCLES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              cs_n_i,
  input  logic              rd_conv_i,
  input  logic              addr_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              addr_viol_o
);
  logic              conv_start, rd_active;
  logic [DATA_W-1:0] result;

  adc_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .cs_n_i(cs_n_i),
    .rd_conv_i(rd_conv_i), .busy_i(busy_o),
    .conv_start_o(conv_start), .rd_active_o(rd_active)
  );

  adc_conv_seq #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(conv_start), .sample_i(sample_i),
    .busy_o(busy_o), .result_o(result)
  );

  adc_out_sel #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_active_i(rd_active), .wide_i(wide_i),
    .addr_i(addr_i), .result_i(result), .data_o(data_o),
    .data_oe_o(data_oe_o), .addr_viol_o(addr_viol_o)
  );
endmodule

// File: rtl/adc_ctrl_emu_chk.sv
module adc_ctrl_emu_chk #(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int CONV_CYCLES = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              cs_n_i,
  input logic              rd_conv_i,
  input logic              wide_i,
  input logic              busy_o,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              addr_viol_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= '0;
  end

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(en_i & ~cs_n_i & ~rd_conv_i));

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == CONV_CYCLES));

  assert_busy_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CONV_CYCLES);

  assert_no_oe_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !data_oe_o);

  assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe_o |-> (data_o == '0));

  assert_byte_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o && !wide_i) |-> (data_o[DATA_W-BYTE_W-1:0] == '0));

  assert_viol_ctx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_viol_o |-> $past(data_oe_o && !wide_i));
endmodule

bind adc_ctrl_emu adc_ctrl_emu_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .cs_n_i(cs_n_i),
  .rd_conv_i(rd_conv_i), .wide_i(wide_i), .busy_o(busy_o),
  .data_o(data_o), .data_oe_o(data_oe_o), .addr_viol_o(addr_viol_o)
);

// File: tb/adc_ctrl_emu_bench.sv
`timescale 1ns/1ps
module adc_ctrl_emu_bench;
  localparam int N = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0, cs_n_i = 1'b1, rd_conv_i = 1'b0;
  logic        addr_i = 1'b0, wide_i = 1'b1;
  logic [11:0] sample_i = '0;
  logic        busy_o, data_oe_o, addr_viol_o;
  logic [11:0] data_o;

  int checks = 0;
  int failures = 0;
  int n;

  always #2.5 clk = ~clk;

  adc_ctrl_emu u_adc_ctrl_emu (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .cs_n_i(cs_n_i),
    .rd_conv_i(rd_conv_i), .addr_i(addr_i), .wide_i(wide_i),
    .sample_i(sample_i), .busy_o(busy_o), .data_o(data_o),
    .data_oe_o(data_oe_o), .addr_viol_o(addr_viol_o)
  );

  // {sample[26:15], wide[14], addr[13], en_last[12], expected[11:0]}
  localparam logic [26:0] VEC [0:8] = '{
    {12'hABC, 1'b1, 1'b0, 1'b0, 12'hABC},
    {12'hABC, 1'b0, 1'b0, 1'b1, 12'hAB0},
    {12'hABC, 1'b0, 1'b1, 1'b0, 12'hC00},
    {12'h5A3, 1'b0, 1'b0, 1'b1, 12'h5A0},
    {12'h5A3, 1'b0, 1'b1, 1'b0, 12'h300},
    {12'hFFF, 1'b0, 1'b1, 1'b1, 12'hF00},
    {12'h001, 1'b0, 1'b0, 1'b0, 12'h000},
    {12'h001, 1'b0, 1'b1, 1'b1, 12'h100},
    {12'h800, 1'b1, 1'b1, 1'b0, 12'h800}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    en_i = 1'b0; cs_n_i = 1'b1; rd_conv_i = 1'b0;
  endtask

  // count busy cycles, starting at the negedge after the start edge
  task automatic count_busy(output int cnt);
    cnt = 0;
    while (busy_o && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 oe", data_oe_o, 0);
    chk("R1 data", data_o, 0);
    chk("R1 viol", addr_viol_o, 0);

    // table walk: R2 start ordering, R3 length, R4 capture, R8/R9 read
    for (int i = 0; i < 9; i++) begin
      logic [26:0] v;
      v = VEC[i];
      idle();
      @(negedge clk);
      sample_i = v[26:15];
      if (v[12]) begin
        en_i = 1'b0; cs_n_i = 1'b0; rd_conv_i = 1'b0;
        @(negedge clk);
        en_i = 1'b1;
      end else begin
        en_i = 1'b1; cs_n_i = 1'b1; rd_conv_i = 1'b0;
        @(negedge clk);
        cs_n_i = 1'b0;
      end
      @(negedge clk);
      chk("R2 busy after start", busy_o, 1);
      cs_n_i = 1'b1;
      sample_i = ~v[26:15];          // R4: late change must not matter
      count_busy(n);
      chk("R3 busy length", n, N);
      en_i = 1'b1; cs_n_i = 1'b0; rd_conv_i = 1'b1;
      wide_i = v[14]; addr_i = v[13];
      #1;
      chk("R7 oe on read", data_oe_o, 1);
      chk("R8 R9 R4 read data", data_o, v[11:0]);
      @(negedge clk);
      cs_n_i = 1'b1;
      #1;
      chk("R7 data zero when not read", data_o, 0);
    end

    // R5: second convert edge during busy is ignored
    idle(); wide_i = 1'b1; addr_i = 1'b0;
    @(negedge clk);
    en_i = 1'b1; sample_i = 12'h3C5; cs_n_i = 1'b0;
    @(negedge clk);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      if (n == 1) cs_n_i = 1'b1;
      if (n == 2) begin cs_n_i = 1'b0; sample_i = 12'h0F0; end
      if (n == 3) cs_n_i = 1'b1;
      @(negedge clk);
    end
    chk("R5 busy length unchanged", n, N);
    cs_n_i = 1'b0; rd_conv_i = 1'b1;
    #1;
    chk("R5 result unchanged", data_o, 12'h3C5);
    @(negedge clk);

    // R6: held convert condition does not restart
    rd_conv_i = 1'b0; sample_i = 12'h777;
    @(negedge clk);
    count_busy(n);
    chk("R6 first conversion length", n, N);
    repeat (4) @(negedge clk);
    chk("R6 no restart while held", busy_o, 0);

    // R10: stand-alone low pulse
    en_i = 1'b1; cs_n_i = 1'b0; addr_i = 1'b0; wide_i = 1'b1;
    rd_conv_i = 1'b1;
    @(negedge clk);
    sample_i = 12'h9E1;
    #1;
    chk("R10 oe while high", data_oe_o, 1);
    rd_conv_i = 1'b0;
    #1;
    chk("R10 float at falling edge", data_oe_o, 0);
    @(negedge clk);
    rd_conv_i = 1'b1;
    #1;
    chk("R10 still floating while busy", data_oe_o, 0);
    count_busy(n);
    chk("R10 busy length", n, N);
    #1;
    chk("R10 oe back after conversion", data_oe_o, 1);
    chk("R10 new data", data_o, 12'h9E1);

    // R11: address change during byte read
    @(negedge clk);
    wide_i = 1'b0; addr_i = 1'b0;
    @(negedge clk);
    chk("R11 no flag when stable", addr_viol_o, 0);
    addr_i = 1'b1;
    @(negedge clk);
    chk("R11 flag after change", addr_viol_o, 1);
    @(negedge clk);
    chk("R11 flag lasts one cycle", addr_viol_o, 0);
    wide_i = 1'b1; addr_i = 1'b0;
    @(negedge clk);
    chk("R11 no flag in 12-bit mode", addr_viol_o, 0);

    idle();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule